// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This block is the bus-master data mover that sits behind a disk-style device controller. Once the controller has decoded a DMA command, it arms the engine with the command's sector count and direction. Software then starts the engine with the address of a descriptor table in system memory. The engine reads one 8-byte descriptor at a time. Each descriptor names a memory region, its length and whether it is the last entry. The engine cuts each region into bursts that never straddle a page. It issues those bursts on a simple request/busy memory port, where the port moves the data between memory and the sector buffer.

A busy memory port is not an error. The engine drops its request, waits a fixed back-off and presents the same request again. Before the first burst of every descriptor it waits a fixed medium latency plus one cycle per sector in that region. It keeps a count of the bytes the command still owes. It cross-checks that count against the descriptor lengths and the end-of-table flag, then reports either a done pulse or an error pulse with a cause code.

Address translation, the storage medium and the task-file registers are outside the block.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset `state_o` is 0 (idle), and `mem_req_o`, `done_o` and `err_o` are low. `state_o` encodes 0 = idle, 1 = armed, 2 = transferring.
- R2: The first descriptor fetch goes to `table_base_i` with bits 1:0 forced to zero. Every fetch has `mem_desc_o` high, `mem_we_o` low and length 8. Each following fetch is at the previous fetch address plus 8.
- R3: A descriptor word carries the region base in bits 31:0, the byte count in bits 47:32 (0 means 65536) and the end-of-table flag in bit 63.
- R4: The length of each burst is the smallest of three values: the region bytes still left, one page (`PAGE_BYTES`) and the distance to the next page boundary. No burst crosses a page boundary, and the bursts of a region cover it in ascending address order.
- R5: A request presented while `mem_busy_i` is high is not taken. The identical request is presented again exactly `BACKOFF_CYCLES + 2` cycles after the refused cycle.
- R6: `mem_we_o` is high on bursts when the command was armed with `to_mem_i` = 1 (data from the medium is written to memory). It is low for `to_mem_i` = 0 (memory is read toward the medium).
- R7: The first burst of each descriptor is first presented `DISK_DELAY + bytes/512 + 2` cycles after the cycle in which `mem_rvalid_i` delivered that descriptor.
- R8: Arming loads the owed byte count as `cmd_sectors_i` × 512, with a sector count of 0 meaning 256 sectors. A descriptor whose byte count exceeds the bytes still owed ends the command with `err_o` and cause 2, and issues no bursts for it.
- R9: After the last burst of a descriptor marked end-of-table, the engine returns to idle. It pulses `done_o` if no bytes are still owed; otherwise it pulses `err_o` with cause 3. After a descriptor without the flag it fetches the next one.
- R10: `arm_i` is taken only in idle, and `start_i` only when armed. A `start_i` in idle starts no memory request and leaves `state_o` at 0.
- R11: `abort_i` while armed or transferring returns the engine to idle on the next cycle and pulses `err_o` with cause 0. In idle it has no effect.
- R12: A descriptor byte count that is not a multiple of 512 ends the command with `err_o` and cause 1, and no burst is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Controller arms a DMA command (idle only) |
| cmd_sectors_i | input | 8 | Command sector count, 0 = 256 |
| to_mem_i | input | 1 | 1 = medium-to-memory (memory writes), 0 = memory-to-medium |
| start_i | input | 1 | Start request from software (armed only) |
| table_base_i | input | 32 | Descriptor table address; bits 1:0 ignored |
| abort_i | input | 1 | Abort the current command |
| mem_req_o | output | 1 | Memory request valid |
| mem_desc_o | output | 1 | Request is a descriptor fetch |
| mem_we_o | output | 1 | Request writes memory |
| mem_addr_o | output | 32 | Request address |
| mem_len_o | output | 17 | Request length in bytes |
| mem_busy_i | input | 1 | Port busy; the request is refused this cycle |
| mem_rvalid_i | input | 1 | Descriptor data valid |
| mem_rdata_i | input | 64 | Descriptor data |
| state_o | output | 2 | 0 idle, 1 armed, 2 transferring |
| done_o | output | 1 | One-cycle pulse on clean completion |
| err_o | output | 1 | One-cycle pulse on error or abort |
| err_cause_o | output | 2 | Cause of the last error: 0 abort, 1 odd size, 2 overrun, 3 end mismatch |

## Verification
Some properties are checked on every cycle:
- every data burst stays inside one page;
- every descriptor fetch is word aligned and 8 bytes long;
- a refused request is withdrawn on the next cycle;
- done and error never coincide, and done only appears in idle;
- idle never jumps straight to transferring;
- an abort outside idle always yields an abort error.

Only the bench's scenarios can show the following:
- the exact burst sequences of multi-descriptor tables that split across pages;
- the precise back-off and medium-delay cycle counts;
- the direction bit;
- the cause codes of the odd-size, overrun and end-mismatch cases.

These scenarios compare the issued requests against an independently computed expectation.

// File: rtl/sg_dma_pkg.sv
// Shared types for the scatter-gather DMA engine.
// Assumes a 64-bit descriptor with a 32-bit base address.
package sg_dma_pkg;

    // Externally visible engine state, as presented on state_o.
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_ARMED  = 2'd1,
        ENG_MOVING = 2'd2
    } eng_state_e;

    // Error cause codes, as presented on err_cause_o.
    typedef enum logic [1:0] {
        CAUSE_ABORT        = 2'd0,
        CAUSE_ODD_SIZE     = 2'd1,
        CAUSE_OVERRUN      = 2'd2,
        CAUSE_EOT_MISMATCH = 2'd3
    } cause_e;

    // Internal sequencer steps.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_FETCH,
        SEQ_FWAIT,
        SEQ_DELAY,
        SEQ_BURST,
        SEQ_BACKOFF
    } seq_e;

endpackage

// File: rtl/dma_desc_decode.sv
// Splits a fetched 64-bit descriptor into region base, byte count and
// last-entry flag. A zero count field stands for the largest region.
// Assumes the base sits in bits 31:0, the count in 47:32, the flag in 63.
module dma_desc_decode #(
    parameter int ADDR_W       = 32,
    parameter int CNT_W        = 16,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [63:0]        word_i,
    output logic [ADDR_W-1:0]  base_o,
    output logic [CNT_W:0]     bytes_o,
    output logic               last_o,
    output logic               odd_size_o,
    output logic [CNT_W:0]     sectors_o
);
    localparam int SEC_SHIFT = $clog2(SECTOR_BYTES);

    logic [CNT_W-1:0] raw_cnt;

    // Field extraction and the zero-means-maximum rule.
    always_comb begin
        raw_cnt    = word_i[32 +: CNT_W];
        base_o     = word_i[ADDR_W-1:0];
        last_o     = word_i[63];
        bytes_o    = (raw_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, raw_cnt};
        odd_size_o = |bytes_o[SEC_SHIFT-1:0];
        sectors_o  = bytes_o >> SEC_SHIFT;
    end

endmodule

// File: rtl/dma_burst_sizer.sv
// Computes the next burst length for a region: the bytes left, capped at
// one page and cut at the next page boundary.
// Assumes PAGE_BYTES is a power of two and no larger than 2**(LEN_W-1).
module dma_burst_sizer #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 17,
    parameter int PAGE_BYTES = 8192
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  left_i,
    output logic [LEN_W-1:0]  len_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE_BYTES);

    logic [LEN_W-1:0] to_bound;
    logic [LEN_W-1:0] capped;

    // Length selection: the smaller of the page cap and the boundary distance.
    always_comb begin
        to_bound = PAGE_LEN - LEN_W'(addr_i[PAGE_W-1:0]);
        capped   = (left_i > PAGE_LEN) ? PAGE_LEN : left_i;
        len_o    = (capped > to_bound) ? to_bound : capped;
    end

endmodule

// File: rtl/dma_wait_timer.sv
// Down-counter for the back-off and medium-delay waits. A load sets the
// count, which then falls by one per cycle; expired_o is high at zero.
// Assumes loads happen only while the sequencer is about to wait.
module dma_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] count_q;

    // Count register: load wins, otherwise decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             count_q <= '0;
        else if (load_i)        count_q <= value_i;
        else if (count_q != '0) count_q <= count_q - 1'b1;
    end

    assign expired_o = (count_q == '0);

    // R5 and R7: a non-zero load always produces a wait.
    a_r5_timer_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && value_i != '0) |=> !expired_o);

endmodule

// File: rtl/sg_dma_engine.sv
// Bus-master scatter-gather DMA engine. It walks a descriptor table,
// splits each region into page-bounded bursts, backs off on a busy port,
// and reports completion or an error cause to the device controller.
// Assumes a memory port that takes a request in any cycle where busy is
// low, and returns descriptor data later with a one-cycle rvalid.
module sg_dma_engine #(
    parameter int ADDR_W         = 32,
    parameter int CNT_W          = 16,
    parameter int SECT_W         = 8,
    parameter int SECTOR_BYTES   = 512,
    parameter int PAGE_BYTES     = 8192,
    parameter int DESC_BYTES     = 8,
    parameter int DISK_DELAY     = 20,
    parameter int BACKOFF_CYCLES = 6,
    parameter int TMR_W          = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_i,
    input  logic [SECT_W-1:0]   cmd_sectors_i,
    input  logic                to_mem_i,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   table_base_i,
    input  logic                abort_i,
    output logic                mem_req_o,
    output logic                mem_desc_o,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [CNT_W:0]      mem_len_o,
    input  logic                mem_busy_i,
    input  logic                mem_rvalid_i,
    input  logic [63:0]         mem_rdata_i,
    output logic [1:0]          state_o,
    output logic                done_o,
    output logic                err_o,
    output logic [1:0]          err_cause_o
);
    import sg_dma_pkg::*;

    localparam int LEN_W     = CNT_W + 1;
    localparam int SEC_SHIFT = $clog2(SECTOR_BYTES);
    localparam int CMD_W     = SECT_W + 1 + SEC_SHIFT;
    localparam int PAGE_W    = $clog2(PAGE_BYTES);

    seq_e              seq_q, ret_q;
    cause_e            cause_q;
    logic [ADDR_W-1:0] prd_addr_q, cur_addr_q;
    logic [LEN_W-1:0]  region_left_q;
    logic [CMD_W-1:0]  cmd_left_q;
    logic              last_q, to_mem_q, done_q, err_q;

    logic [ADDR_W-1:0] d_base;
    logic [LEN_W-1:0]  d_bytes, d_sectors, burst_len;
    logic              d_last, d_odd;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_value;
    logic              refused;

    dma_desc_decode #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_decode (
        .word_i(mem_rdata_i), .base_o(d_base), .bytes_o(d_bytes),
        .last_o(d_last), .odd_size_o(d_odd), .sectors_o(d_sectors)
    );

    dma_burst_sizer #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_sizer (
        .addr_i(cur_addr_q), .left_i(region_left_q), .len_o(burst_len)
    );

    dma_wait_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .value_i(tmr_value), .expired_o(tmr_expired)
    );

    // Timer control: back-off on refusal, medium delay on descriptor arrival.
    always_comb begin
        refused   = mem_req_o && mem_busy_i;
        tmr_load  = refused || (seq_q == SEQ_FWAIT && mem_rvalid_i);
        tmr_value = refused ? TMR_W'(BACKOFF_CYCLES)
                            : TMR_W'(DISK_DELAY) + TMR_W'(d_sectors);
    end

    // Memory port drive: descriptor fetch or data burst.
    always_comb begin
        mem_req_o  = (seq_q == SEQ_FETCH) || (seq_q == SEQ_BURST);
        mem_desc_o = (seq_q == SEQ_FETCH);
        mem_we_o   = (seq_q == SEQ_BURST) && to_mem_q;
        mem_addr_o = mem_desc_o ? prd_addr_q : cur_addr_q;
        mem_len_o  = mem_desc_o ? LEN_W'(DESC_BYTES) : burst_len;
    end

    // Sequencer: command arming, descriptor walk, bursts and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q         <= SEQ_IDLE;
            ret_q         <= SEQ_FETCH;
            cause_q       <= CAUSE_ABORT;
            prd_addr_q    <= '0;
            cur_addr_q    <= '0;
            region_left_q <= '0;
            cmd_left_q    <= '0;
            last_q        <= 1'b0;
            to_mem_q      <= 1'b0;
            done_q        <= 1'b0;
            err_q         <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (abort_i && seq_q != SEQ_IDLE) begin
                seq_q   <= SEQ_IDLE;
                err_q   <= 1'b1;
                cause_q <= CAUSE_ABORT;
            end else begin
                case (seq_q)
                    SEQ_IDLE: if (arm_i) begin
                        seq_q      <= SEQ_ARMED;
                        to_mem_q   <= to_mem_i;
                        cmd_left_q <= CMD_W'({(cmd_sectors_i == '0), cmd_sectors_i}) << SEC_SHIFT;
                    end
                    SEQ_ARMED: if (start_i) begin
                        seq_q      <= SEQ_FETCH;
                        prd_addr_q <= {table_base_i[ADDR_W-1:2], 2'b00};
                    end
                    SEQ_FETCH: begin
                        if (mem_busy_i) begin
                            ret_q <= SEQ_FETCH;
                            seq_q <= SEQ_BACKOFF;
                        end else begin
                            seq_q <= SEQ_FWAIT;
                        end
                    end
                    SEQ_FWAIT: if (mem_rvalid_i) begin
                        prd_addr_q    <= prd_addr_q + ADDR_W'(DESC_BYTES);
                        cur_addr_q    <= d_base;
                        region_left_q <= d_bytes;
                        last_q        <= d_last;
                        if (d_odd) begin
                            seq_q   <= SEQ_IDLE;
                            err_q   <= 1'b1;
                            cause_q <= CAUSE_ODD_SIZE;
                        end else if (CMD_W'(d_bytes) > cmd_left_q) begin
                            seq_q   <= SEQ_IDLE;
                            err_q   <= 1'b1;
                            cause_q <= CAUSE_OVERRUN;
                        end else begin
                            seq_q <= SEQ_DELAY;
                        end
                    end
                    SEQ_DELAY: if (tmr_expired) seq_q <= SEQ_BURST;
                    SEQ_BURST: begin
                        if (mem_busy_i) begin
                            ret_q <= SEQ_BURST;
                            seq_q <= SEQ_BACKOFF;
                        end else begin
                            cur_addr_q    <= cur_addr_q + ADDR_W'(burst_len);
                            region_left_q <= region_left_q - burst_len;
                            cmd_left_q    <= cmd_left_q - CMD_W'(burst_len);
                            if (region_left_q == burst_len) begin
                                if (!last_q) begin
                                    seq_q <= SEQ_FETCH;
                                end else if (cmd_left_q == CMD_W'(burst_len)) begin
                                    seq_q  <= SEQ_IDLE;
                                    done_q <= 1'b1;
                                end else begin
                                    seq_q   <= SEQ_IDLE;
                                    err_q   <= 1'b1;
                                    cause_q <= CAUSE_EOT_MISMATCH;
                                end
                            end
                        end
                    end
                    SEQ_BACKOFF: if (tmr_expired) seq_q <= ret_q;
                    default: seq_q <= SEQ_IDLE;
                endcase
            end
        end
    end

    // Output mapping of the sequencer to the coarse engine state.
    always_comb begin
        case (seq_q)
            SEQ_IDLE:  state_o = ENG_IDLE;
            SEQ_ARMED: state_o = ENG_ARMED;
            default:   state_o = ENG_MOVING;
        endcase
    end

    assign done_o      = done_q;
    assign err_o       = err_q;
    assign err_cause_o = cause_q;

    // R4: a data burst stays inside one page.
    a_r4_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_desc_o) |->
        ((LEN_W+1)'(mem_addr_o[PAGE_W-1:0]) + (LEN_W+1)'(mem_len_o) <= (LEN_W+1)'(PAGE_BYTES))
        && mem_len_o != '0);

    // R2: descriptor fetches are word aligned reads of one descriptor.
    a_r2_fetch_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_desc_o) |->
        (mem_addr_o[1:0] == 2'b00 && mem_len_o == LEN_W'(DESC_BYTES) && !mem_we_o));

    // R5: a refused request is withdrawn for the back-off.
    a_r5_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_busy_i) |=> !mem_req_o);

    // R9: done only lands in idle and never together with an error.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_o == ENG_IDLE && !err_o));

    // R10: idle can only move to armed, never straight to transfer.
    a_r10_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ENG_IDLE) |=> (state_o != ENG_MOVING));

    // R11: an abort outside idle yields an abort error in idle.
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && state_o != ENG_IDLE) |=>
        (err_o && err_cause_o == CAUSE_ABORT && state_o == ENG_IDLE));

endmodule

// File: tb/sg_dma_engine_tb.sv
module sg_dma_engine_tb;
    localparam int DD   = 20;
    localparam int BO   = 6;
    localparam int PAGE = 8192;
    localparam logic [31:0] TBL = 32'h0000_1000;

    typedef struct packed { logic [31:0] a; logic [16:0] l; logic w; } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm_i = 0, to_mem_i = 0, start_i = 0, abort_i = 0;
    logic [7:0]  cmd_sectors_i = 0;
    logic [31:0] table_base_i = 0;
    logic mem_req_o, mem_desc_o, mem_we_o, done_o, err_o;
    logic [31:0] mem_addr_o;
    logic [16:0] mem_len_o;
    logic mem_busy_i, mem_rvalid_i;
    logic [63:0] mem_rdata_i;
    logic [1:0] state_o, err_cause_o;

    sg_dma_engine #(.PAGE_BYTES(PAGE), .DISK_DELAY(DD), .BACKOFF_CYCLES(BO)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .cmd_sectors_i(cmd_sectors_i),
        .to_mem_i(to_mem_i), .start_i(start_i), .table_base_i(table_base_i),
        .abort_i(abort_i), .mem_req_o(mem_req_o), .mem_desc_o(mem_desc_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
        .mem_busy_i(mem_busy_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .state_o(state_o), .done_o(done_o), .err_o(err_o), .err_cause_o(err_cause_o)
    );

    always #10 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    logic [63:0] desc_mem [0:7];
    item_t       burst_q[$];
    logic [31:0] fetch_q[$];
    int refuse_fetch = 0, refuse_burst = 0, rv_timer = 0;
    int rv_cycle = 0, exp_delay = 0, refused_cyc = 0, bursts_taken = 0, reqs_seen = 0;
    bit await_first = 0, chk_retry = 0, got_done = 0, got_err = 0;
    logic [1:0]  got_cause = 0;
    logic [31:0] rv_addr = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model and monitor: refuses, answers fetches, pops the scoreboard.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_busy_i = 0; mem_rvalid_i = 0; mem_rdata_i = '0; rv_timer = 0;
        end else begin
            mem_rvalid_i = 0;
            if (rv_timer == 1) begin
                logic [63:0] w;
                int bytes;
                w = desc_mem[((rv_addr - TBL) >> 3) & 7];
                mem_rvalid_i = 1; mem_rdata_i = w; rv_cycle = cyc;
                bytes = (w[47:32] == 0) ? 65536 : int'(w[47:32]);
                exp_delay = DD + bytes / 512 + 2;
                await_first = 1;
            end
            if (rv_timer > 0) rv_timer--;
            mem_busy_i = 0;
            if (mem_req_o) begin
                reqs_seen++;
                if (chk_retry) begin
                    chk(cyc - refused_cyc == BO + 2, "R5 retry gap", cyc - refused_cyc, BO + 2);
                    chk_retry = 0;
                end
                if (!mem_desc_o && await_first) begin
                    chk(cyc - rv_cycle == exp_delay, "R7 first burst delay", cyc - rv_cycle, exp_delay);
                    await_first = 0;
                end
                if (mem_desc_o ? (refuse_fetch > 0) : (refuse_burst > 0)) begin
                    mem_busy_i = 1;
                    if (mem_desc_o) refuse_fetch--; else refuse_burst--;
                    refused_cyc = cyc; chk_retry = 1;
                end else if (mem_desc_o) begin
                    if (fetch_q.size() == 0) chk(0, "R2 unexpected fetch", mem_addr_o, 0);
                    else begin
                        logic [31:0] ea;
                        ea = fetch_q.pop_front();
                        chk(mem_addr_o == ea, "R2 fetch address", mem_addr_o, ea);
                    end
                    rv_timer = 2; rv_addr = mem_addr_o;
                end else begin
                    bursts_taken++;
                    if (burst_q.size() == 0) chk(0, "R4 unexpected burst", mem_addr_o, 0);
                    else begin
                        item_t e;
                        e = burst_q.pop_front();
                        chk(mem_addr_o == e.a, "R4 burst address", mem_addr_o, e.a);
                        chk(mem_len_o == e.l, "R4 burst length", mem_len_o, e.l);
                        chk(mem_we_o == e.w, "R6 burst direction", mem_we_o, e.w);
                    end
                end
            end
            if (done_o) got_done = 1;
            if (err_o) begin got_err = 1; got_cause = err_cause_o; end
        end
    end

    // Driver: push the expected page-cut bursts of one region.
    task automatic push_region(input logic [31:0] base, input int bytes, input bit w);
        int rem = bytes;
        logic [31:0] a = base;
        while (rem > 0) begin
            int cap, tb, len;
            item_t it;
            cap = (rem > PAGE) ? PAGE : rem;
            tb  = PAGE - int'(a % PAGE);
            len = (cap > tb) ? tb : cap;
            it.a = a; it.l = 17'(len); it.w = w;
            burst_q.push_back(it);
            a += len; rem -= len;
        end
    endtask

    task automatic set_desc(input int idx, input logic [31:0] base, input logic [15:0] cnt, input bit eot);
        desc_mem[idx] = {eot, 15'd0, cnt, base};
    endtask

    task automatic run_cmd(input logic [7:0] secs, input bit tm, input logic [31:0] tb,
                           input bit want_err, input logic [1:0] cause, input string tag);
        int n = 0;
        got_done = 0; got_err = 0; await_first = 0; chk_retry = 0;
        @(negedge clk); arm_i = 1; cmd_sectors_i = secs; to_mem_i = tm;
        @(negedge clk); arm_i = 0;
        chk(state_o == 2'd1, {tag, " armed state"}, state_o, 1);
        start_i = 1; table_base_i = tb;
        @(negedge clk); start_i = 0;
        while (!got_done && !got_err && n < 20000) begin @(posedge clk); n++; end
        @(posedge clk);
        chk(got_err == want_err && got_done == !want_err, {tag, " outcome"}, got_err, want_err);
        if (want_err) chk(got_cause == cause, {tag, " cause"}, got_cause, cause);
        chk(state_o == 2'd0, {tag, " back to idle"}, state_o, 0);
        chk(burst_q.size() == 0 && fetch_q.size() == 0, {tag, " scoreboard drained"},
            burst_q.size() + fetch_q.size(), 0);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(state_o == 0 && !mem_req_o && !done_o && !err_o, "R1 reset state", state_o, 0);

        // R2 R3 R6 R7 R9: one region, memory read, low table bits dropped
        set_desc(0, 32'h0002_0000, 16'd1024, 1);
        fetch_q.push_back(TBL); push_region(32'h0002_0000, 1024, 0);
        run_cmd(8'd2, 0, TBL | 32'h3, 0, 0, "R9 single region");

        // R2 R3 R4 R6: two regions cut at page boundaries, memory write
        set_desc(0, 32'h0000_3E00, 16'h4400, 0);
        set_desc(1, 32'h0001_0100, 16'h0400, 1);
        fetch_q.push_back(TBL); fetch_q.push_back(TBL + 8);
        push_region(32'h0000_3E00, 'h4400, 1); push_region(32'h0001_0100, 'h400, 1);
        run_cmd(8'd36, 1, TBL, 0, 0, "R4 page split");

        // R5: refusals of a fetch and of a burst
        refuse_fetch = 1; refuse_burst = 2;
        set_desc(0, 32'h0000_9000, 16'd1024, 1);
        fetch_q.push_back(TBL); push_region(32'h0000_9000, 1024, 0);
        run_cmd(8'd2, 0, TBL, 0, 0, "R5 back-off");

        // R3: zero count field means 65536 bytes
        set_desc(0, 32'h0001_0000, 16'd0, 1);
        fetch_q.push_back(TBL); push_region(32'h0001_0000, 65536, 1);
        run_cmd(8'd128, 1, TBL, 0, 0, "R3 zero count");

        // R8: sector count 0 means 256 sectors, two maximal regions
        set_desc(0, 32'h0010_0000, 16'd0, 0);
        set_desc(1, 32'h0020_0000, 16'd0, 1);
        fetch_q.push_back(TBL); fetch_q.push_back(TBL + 8);
        push_region(32'h0010_0000, 65536, 0); push_region(32'h0020_0000, 65536, 0);
        run_cmd(8'd0, 0, TBL, 0, 0, "R8 full command");

        // R12: odd region size
        set_desc(0, 32'h0000_4000, 16'd100, 1);
        fetch_q.push_back(TBL);
        run_cmd(8'd1, 0, TBL, 1, 2'd1, "R12 odd size");

        // R8: region longer than the command owes
        set_desc(0, 32'h0000_4000, 16'd1024, 1);
        fetch_q.push_back(TBL);
        run_cmd(8'd1, 0, TBL, 1, 2'd2, "R8 overrun");

        // R9: end-of-table with bytes still owed
        set_desc(0, 32'h0000_4000, 16'd512, 1);
        fetch_q.push_back(TBL); push_region(32'h0000_4000, 512, 1);
        run_cmd(8'd4, 1, TBL, 1, 2'd3, "R9 end mismatch");

        // R11: abort in the middle of a transfer
        got_err = 0; got_done = 0;
        set_desc(0, 32'h0001_0000, 16'd0, 1);
        fetch_q.push_back(TBL); push_region(32'h0001_0000, 65536, 0);
        bursts_taken = 0;
        @(negedge clk); arm_i = 1; cmd_sectors_i = 8'd128; to_mem_i = 0;
        @(negedge clk); arm_i = 0; start_i = 1; table_base_i = TBL;
        @(negedge clk); start_i = 0;
        while (bursts_taken < 2) @(posedge clk);
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
        @(posedge clk);
        chk(got_err && got_cause == 2'd0, "R11 abort cause", got_cause, 0);
        chk(state_o == 0, "R11 abort to idle", state_o, 0);
        burst_q.delete(); fetch_q.delete();

        // R11: abort in idle has no effect
        got_err = 0;
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
        repeat (3) @(posedge clk);
        chk(!got_err && state_o == 0, "R11 idle abort ignored", got_err, 0);

        // R10: start in idle is ignored
        seen = reqs_seen;
        @(negedge clk); start_i = 1; table_base_i = TBL;
        @(negedge clk); start_i = 0;
        repeat (6) @(posedge clk);
        chk(state_o == 0, "R10 idle start state", state_o, 0);
        chk(reqs_seen == seen, "R10 idle start no request", reqs_seen - seen, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule